// File: doc/BRIEF.md
# Edge Timestamp Unit with Glitch Rejection

This block carries its own free-running 16-bit tick counter. It records the time of selected transitions on an asynchronous input pin. When a transition of the chosen polarity arrives, the counter value is stored in a 16-bit stamp register and an event flag is raised. The flag can drive an interrupt line when the interrupt enable is set. An optional glitch rejector passes a level change on only after the pin has held that level for four consecutive clock samples.

Software reaches the block over a byte-wide register bus. 16-bit quantities are moved as whole words through one shared high-byte holding register:
- Reading a low byte parks the matching high byte in the holding register.
- Writing a high byte parks it in the holding register.
- Writing a low byte commits the holding byte and the new low byte together.

The stamp register can also be chosen as the counter's wrap limit. While it serves that role, pin events store nothing.

Top module: `edge_stamp_unit`

## Requirements
- R1: After synchronous reset the counter starts from 0, and the control register (address 4) reads 0. The status register (address 5) reads 0. `bus_rdata` and `irq` are 0.
- R2: With control bit 2 clear, the counter advances by one every clock and wraps from 0xFFFF to 0x0000.
- R3: With control bit 0 set, a rising pin edge stores the counter into the stamp register and sets status bit 0. A pin change first seen at clock edge k stores the counter value held just before edge k+2 when the glitch rejector is off.
- R4: With control bit 0 clear, only falling edges store a stamp. An edge of the other polarity leaves the flag and the stamp register unchanged.
- R5: With control bit 1 set, the pin must hold a new level for 4 consecutive clock samples before it counts as an edge. A pulse of 3 samples or fewer is ignored. An accepted edge is stored 4 clocks later than with the rejector off.
- R6: `irq` is high one clock after status bit 0 and control bit 3 are both high. It drops one clock after either one goes low.
- R7: Writing status with bit 0 = 1 clears the flag. Writing it with bit 0 = 0 has no effect. A one-clock `irq_ack` pulse also clears the flag. A new event in the same clock wins over either clear.
- R8: Reading address 0 (counter) or address 2 (stamp) returns the low byte one clock after the read strobe and latches the high byte into the holding register. Reading address 1 or 3 returns the holding register, so the two bytes come from the same instant.
- R9: Writing address 1 or 3 only loads the holding register. Writing address 0 or 2 commits {holding, data} to the counter or stamp register. The holding register is shared, so the last high byte written by either path is used.
- R10: With control bit 2 set, the counter counts from 0 up to the stamp value and then returns to 0. Pin edges neither store a stamp nor set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_pin | input | 1 | Asynchronous event pin |
| bus_addr | input | 3 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_ack | input | 1 | Service acknowledge, clears the flag |
| irq | output | 1 | Interrupt request |

## Verification
The counter is read as word pairs from start points just below a byte carry and just below the full wrap. This separates a coherent high-byte latch from a live high-byte read. Stamps are taken with both polarities and with the rejector off and on. Pulse widths from one to six samples are swept to pin the four-sample acceptance threshold, and the measured stamp offsets tell the two latencies apart. The wrap-limit mode is tried with several limit values, which shows both the shortened count sequence and the blocking of pin events.

// File: rtl/stamp_pkg.sv
`timescale 1ns/1ps
package stamp_pkg;
  // byte addresses on the register bus
  localparam logic [2:0] ADR_CNT_LO = 3'd0;
  localparam logic [2:0] ADR_CNT_HI = 3'd1;
  localparam logic [2:0] ADR_CAP_LO = 3'd2;
  localparam logic [2:0] ADR_CAP_HI = 3'd3;
  localparam logic [2:0] ADR_CTRL   = 3'd4;
  localparam logic [2:0] ADR_STAT   = 3'd5;
  // control register bit positions
  localparam int B_RISE = 0;
  localparam int B_FILT = 1;
  localparam int B_TOP  = 2;
  localparam int B_IEN  = 3;
endpackage

// File: rtl/stamp_input_cond.sv
`timescale 1ns/1ps
module stamp_input_cond #(
  parameter int SYNC = 2,
  parameter int FLT  = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic filt_en,
  input  logic rise_sel,
  output logic edge_evt
);
  logic [SYNC-1:0] sync_q;
  logic            pin_s;
  logic [FLT-2:0]  hist_q;
  logic [FLT-1:0]  win;
  logic            filt_q;
  logic            prev_q;
  logic            sel;

  assign pin_s = sync_q[SYNC-1];
  assign win   = {hist_q, pin_s};
  assign sel   = filt_en ? filt_q : pin_s;

  generate
    if (SYNC == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= pin;
      end
    end else begin : g_syncn
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC-2:0], pin};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
      filt_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      hist_q <= win[FLT-2:0];
      if (&win)       filt_q <= 1'b1;
      else if (~|win) filt_q <= 1'b0;
      prev_q <= sel;
    end
  end

  assign edge_evt = rise_sel ? (sel & ~prev_q) : (~sel & prev_q);
endmodule

// File: rtl/stamp_counter.sv
`timescale 1ns/1ps
module stamp_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         top_en,
  input  logic [W-1:0] top_val,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)                            count <= '0;
    else if (load)                      count <= load_val;
    else if (top_en && count == top_val) count <= '0;
    else                                count <= count + 1'b1;
  end
endmodule

// File: rtl/edge_stamp_unit.sv
`timescale 1ns/1ps
module edge_stamp_unit #(
  parameter int BUS_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_pin,
  input  logic [2:0]       bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic             irq_ack,
  output logic             irq
);
  import stamp_pkg::*;
  localparam int CW = 2 * BUS_W;

  logic [CW-1:0]    cnt_q;
  logic [CW-1:0]    cap_q;
  logic [BUS_W-1:0] tmp_q;
  logic [BUS_W-1:0] ctrl_q;
  logic             flag_q;
  logic             pin_evt;
  logic             cap_evt;
  logic             cnt_ld;
  logic             cap_ld;
  logic             w1c;
  logic [CW-1:0]    ld_val;

  assign cnt_ld  = bus_wr && (bus_addr == ADR_CNT_LO);
  assign cap_ld  = bus_wr && (bus_addr == ADR_CAP_LO);
  assign w1c     = bus_wr && (bus_addr == ADR_STAT) && bus_wdata[0];
  assign ld_val  = {tmp_q, bus_wdata};
  assign cap_evt = pin_evt && !ctrl_q[B_TOP];

  stamp_input_cond #(.SYNC(SYNC_STAGES), .FLT(FILT_LEN)) i_cond (
    .clk      (clk),
    .rst      (rst),
    .pin      (cap_pin),
    .filt_en  (ctrl_q[B_FILT]),
    .rise_sel (ctrl_q[B_RISE]),
    .edge_evt (pin_evt)
  );

  stamp_counter #(.W(CW)) i_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (cnt_ld),
    .load_val (ld_val),
    .top_en   (ctrl_q[B_TOP]),
    .top_val  (cap_q),
    .count    (cnt_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q     <= '0;
      tmp_q     <= '0;
      ctrl_q    <= '0;
      flag_q    <= 1'b0;
      irq       <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (bus_wr) begin
        case (bus_addr)
          ADR_CNT_HI, ADR_CAP_HI: tmp_q  <= bus_wdata;
          ADR_CTRL:               ctrl_q <= bus_wdata;
          default: ;
        endcase
      end
      if (cap_ld)       cap_q <= ld_val;
      else if (cap_evt) cap_q <= cnt_q;

      if (cap_evt)               flag_q <= 1'b1;
      else if (w1c || irq_ack)   flag_q <= 1'b0;

      irq <= flag_q & ctrl_q[B_IEN];

      if (bus_rd) begin
        case (bus_addr)
          ADR_CNT_LO: begin
            bus_rdata <= cnt_q[BUS_W-1:0];
            tmp_q     <= cnt_q[CW-1:BUS_W];
          end
          ADR_CAP_LO: begin
            bus_rdata <= cap_q[BUS_W-1:0];
            tmp_q     <= cap_q[CW-1:BUS_W];
          end
          ADR_CNT_HI, ADR_CAP_HI: bus_rdata <= tmp_q;
          ADR_CTRL:               bus_rdata <= ctrl_q;
          ADR_STAT:               bus_rdata <= BUS_W'(flag_q);
          default:                bus_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/stamp_chk.sv
`timescale 1ns/1ps
module stamp_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] cap,
  input logic          flag,
  input logic          irq,
  input logic          ien,
  input logic          top_sel,
  input logic          cap_evt,
  input logic          cnt_ld,
  input logic          cap_ld,
  input logic          ack
);
  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!top_sel && !cnt_ld) |=> (cnt == CW'($past(cnt) + 1'b1)));

  // R3
  stamp_load_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(flag) && !$past(cap_ld)) |-> (cap == $past(cnt)));

  // R6
  irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(ien));

  // R7
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && !cap_evt) |=> !flag);

  // R10
  top_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (top_sel && !cap_ld) |=> $stable(cap));

  // R10
  top_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (top_sel && cnt == cap && !cnt_ld) |=> (cnt == '0));
endmodule

bind edge_stamp_unit stamp_chk #(.CW(2*BUS_W)) i_stamp_chk (
  .clk     (clk),
  .rst     (rst),
  .cnt     (cnt_q),
  .cap     (cap_q),
  .flag    (flag_q),
  .irq     (irq),
  .ien     (ctrl_q[stamp_pkg::B_IEN]),
  .top_sel (ctrl_q[stamp_pkg::B_TOP]),
  .cap_evt (cap_evt),
  .cnt_ld  (cnt_ld),
  .cap_ld  (cap_ld),
  .ack     (irq_ack)
);

// File: tb/test_edge_stamp_unit.sv
`timescale 1ns/1ps
module test_edge_stamp_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cap_pin = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       irq_ack = 1'b0;
  logic       irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int base_v = 0;
  int base_c = 0;
  int per = 65536;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  edge_stamp_unit i_edge_stamp_unit (
    .clk(clk), .rst(rst), .cap_pin(cap_pin), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_ack(irq_ack), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int model(input int c);
    return (base_v + c - 1 - base_c) % per;
  endfunction

  task automatic wr(input logic [2:0] a, input int d);
    @(negedge clk); bus_addr = a; bus_wdata = d[7:0]; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int d, output int c);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata; c = cyc;
  endtask

  task automatic rd16(input logic [2:0] lo, output int v, output int c);
    int l, h, c2;
    rd(lo, l, c);
    rd(lo + 3'd1, h, c2);
    v = (h << 8) | l;
  endtask

  task automatic set_cnt(input int v);
    wr(3'd1, v >> 8);
    wr(3'd0, v & 255);
    base_c = cyc; base_v = v;
  endtask

  task automatic pin_to(input logic v, output int n);
    @(negedge clk); cap_pin = v; n = cyc;
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v, c, n, prev, s;
    repeat (4) @(negedge clk);
    rst = 1'b0; base_c = cyc; base_v = 0;
    // R1 reset state
    chk("R1 rdata", bus_rdata, 0);
    chk("R1 irq", irq, 0);
    rd(3'd4, v, c); chk("R1 ctrl", v, 0);
    rd(3'd5, v, c); chk("R1 status", v, 0);
    rd16(3'd0, v, c); chk("R1 counter from zero", v, model(c));

    // R2 R8 byte-carry and full-wrap sweeps with coherent word reads
    set_cnt(16'h12FC);
    for (int i = 0; i < 6; i++) begin
      idle(i); rd16(3'd0, v, c); chk("R8 coherent word", v, model(c));
    end
    set_cnt(16'hFFFB);
    for (int i = 0; i < 4; i++) begin
      rd16(3'd0, v, c); chk("R2 wrap count", v, model(c));
    end

    // R9 high write alone does not touch counter; shared holding byte
    wr(3'd1, 8'hAB);
    rd16(3'd0, v, c); chk("R9 hi write only", v, model(c));
    wr(3'd1, 8'h34); wr(3'd3, 8'h77); wr(3'd0, 8'h56);
    base_c = cyc; base_v = 16'h7756;
    rd16(3'd0, v, c); chk("R9 shared holding commit", v, model(c));

    // R3 rising capture sweep, R4 opposite edge ignored
    wr(3'd4, 1);
    for (int k = 0; k < 4; k++) begin
      set_cnt(16'h0140 + k * 16'h0101);
      wr(3'd5, 1);
      pin_to(1'b1, n); idle(8);
      rd(3'd5, s, c); chk("R3 flag set", s, 1);
      rd16(3'd2, v, c); chk("R3 stamp value", v, model(n + 3));
      prev = v;
      wr(3'd5, 1);
      pin_to(1'b0, n); idle(8);
      rd(3'd5, s, c); chk("R4 falling ignored in rise mode", s, 0);
      rd16(3'd2, v, c); chk("R4 stamp kept", v, prev);
    end

    // R4 falling mode
    wr(3'd4, 0);
    set_cnt(16'h0A00);
    wr(3'd5, 1);
    pin_to(1'b1, n); idle(8);
    rd(3'd5, s, c); chk("R4 rising ignored in fall mode", s, 0);
    pin_to(1'b0, n); idle(8);
    rd(3'd5, s, c); chk("R4 fall flag", s, 1);
    rd16(3'd2, v, c); chk("R4 fall stamp", v, model(n + 3));

    // R5 filtered latency and pulse-width sweep
    wr(3'd4, 3); idle(8); wr(3'd5, 1);
    set_cnt(16'h2000);
    pin_to(1'b1, n); idle(10);
    rd16(3'd2, v, c); chk("R5 filtered latency", v, model(n + 7));
    pin_to(1'b0, n); idle(10);
    for (int w = 1; w <= 6; w++) begin
      wr(3'd5, 1);
      rd16(3'd2, prev, c);
      pin_to(1'b1, n); idle(w); cap_pin = 1'b0; idle(10);
      rd(3'd5, s, c); chk("R5 pulse flag", s, (w >= 4) ? 1 : 0);
      rd16(3'd2, v, c); chk("R5 pulse stamp", v, (w >= 4) ? model(n + 7) : prev);
    end
    wr(3'd4, 1); wr(3'd5, 1);
    pin_to(1'b1, n); idle(1); cap_pin = 1'b0; idle(8);
    rd(3'd5, s, c); chk("R5 short pulse passes unfiltered", s, 1);

    // R6 interrupt timing
    wr(3'd4, 9); wr(3'd5, 1); idle(2);
    chk("R6 irq idle", irq, 0);
    pin_to(1'b1, n); idle(3);
    chk("R6 irq not yet", irq, 0);
    idle(1); chk("R6 irq raised", irq, 1);
    wr(3'd4, 1); idle(1);
    chk("R6 irq off with enable clear", irq, 0);
    rd(3'd5, s, c); chk("R6 flag kept", s, 1);

    // R7 clearing
    wr(3'd4, 9); idle(2);
    chk("R7 irq back", irq, 1);
    wr(3'd5, 0);
    rd(3'd5, s, c); chk("R7 write zero no effect", s, 1);
    wr(3'd5, 1);
    rd(3'd5, s, c); chk("R7 w1c clears", s, 0);
    chk("R7 irq dropped", irq, 0);
    pin_to(1'b0, n); idle(8);
    pin_to(1'b1, n); idle(8);
    rd(3'd5, s, c); chk("R7 flag before ack", s, 1);
    @(negedge clk); irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    rd(3'd5, s, c); chk("R7 ack clears", s, 0);
    pin_to(1'b0, n); idle(8);

    // R10 stamp register as wrap limit
    foreach (s_top[t]) begin
      wr(3'd4, 5);
      wr(3'd3, 0); wr(3'd2, s_top[t]);
      per = s_top[t] + 1;
      set_cnt(0);
      for (int i = 0; i < 4; i++) begin
        idle(i + t); rd(3'd0, v, c); chk("R10 limited count", v, model(c));
      end
      wr(3'd5, 1);
      pin_to(1'b1, n); idle(8);
      rd(3'd5, s, c); chk("R10 no flag in limit mode", s, 0);
      rd16(3'd2, v, c); chk("R10 stamp kept as limit", v, s_top[t]);
      pin_to(1'b0, n); idle(8);
    end
    wr(3'd4, 1); per = 65536;
    set_cnt(16'h0300);
    rd16(3'd0, v, c); chk("R2 free count restored", v, model(c));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  int s_top[3] = '{3, 6, 10};
endmodule